// File: doc/BRIEF.md
# Dual-Protocol External Bus Bridge

This block turns requests from an internal processor port into cycles on the external bus. Each access takes one of two forms. The first form has separate address and data pins and a data path 16 bits wide. The target reports its width with each cycle end, so the bus width is dynamic. The second form is an 8-bit cycle in which the low address byte and the data byte share the same pins, and its own strobes control it. A select bit on each request picks the form. A system address decoder drives that bit from the address range it recognises.

The internal side is a request/acknowledge port. It carries a 24-bit address, 16-bit write data, two byte enables and a write flag. The requester holds its request until the acknowledge. The bridge splits a 16-bit access into two byte cycles when the target is only 8 bits wide: always when the multiplexed form is chosen, and when a separate-bus target reports an 8-bit port. It assembles read data and gives one acknowledge after the last external cycle.

Top module: `dual_bus_bridge`

## Requirements
- R1: With `req_mux`=0 the access runs only on the separate bus (`nb_as_n` low, `mx_ale` low, both multiplexed strobes high). With `req_mux`=1 it runs only on the multiplexed pins, and `nb_as_n` stays high throughout.
- R2: During a separate-bus cycle, `nb_addr` is the request address with bit 0 cleared for a cycle that includes the even byte and set for an odd-byte-only cycle. `nb_rw` is 1 for a read and 0 for a write. `req_be[1]` selects the even byte on `nb_din/nb_dout[15:8]` and drives `nb_uds_n` low. `req_be[0]` selects the odd byte on `[7:0]` and drives `nb_lds_n` low. `nb_doe` is high only for writes.
- R3: A separate-bus cycle keeps its address and strobes steady until a clock edge samples `nb_dtack_n` low. That edge ends the cycle.
- R4: A two-byte access that ends with `nb_size8`=1 runs a second cycle at the odd address with only `nb_lds_n` low. In that cycle the odd byte travels on `[15:8]`: the write byte appears on both halves of `nb_dout`, and the read byte is taken from `nb_din[15:8]` into `req_rdata[7:0]`. The first cycle supplies `req_rdata[15:8]`.
- R5: A two-byte access that ends with `nb_size8`=0 completes in one cycle with `req_rdata`=`nb_din`. An odd-byte-only read takes `nb_din[7:0]` from a 16-bit port and `nb_din[15:8]` from an 8-bit port.
- R6: A multiplexed byte cycle has three phases of `MX_PHASE_CLKS` clocks each. First, `mx_ale` is high and `mx_ad_out` carries `{addr[7:1], odd}`. Second, `mx_ale` is low, the address is still driven and both strobes are high. Third, `mx_rd_n` or `mx_wr_n` is low. `mx_addr_hi` carries `addr[23:8]`. The two strobes are never low together.
- R7: During the strobe phase of a multiplexed write, `mx_ad_out` carries the byte with `mx_ad_oe`=1. During a multiplexed read, `mx_ad_oe`=0 and `mx_ad_in` is sampled on the final strobe clock.
- R8: A two-byte multiplexed access runs the even byte first, using `wdata[15:8]` and filling `rdata[15:8]`. It then runs the odd byte, using `wdata[7:0]` and filling `rdata[7:0]`.
- R9: `req_ack` is high for exactly one clock, with no external cycle active, after the last byte cycle. `req_rdata` holds the assembled read data at that point, and bytes not read are 0.
- R10: A request with `req_be`=00 is acknowledged without any external cycle.
- R11: After reset, `req_ack`=0, `req_rdata`=0, all active-low strobes are high, and `mx_ale`, `nb_doe` and `mx_ad_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request, held until acknowledged |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data, even byte in [15:8] |
| req_be | input | 2 | Byte enables: [1] even byte, [0] odd byte |
| req_write | input | 1 | 1 write, 0 read |
| req_mux | input | 1 | 1 selects the multiplexed 8-bit form |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Assembled read data |
| nb_addr | output | 24 | Separate-bus address |
| nb_as_n | output | 1 | Separate-bus address strobe, active low |
| nb_rw | output | 1 | 1 read, 0 write |
| nb_uds_n | output | 1 | Even-byte (upper lane) strobe, active low |
| nb_lds_n | output | 1 | Odd-byte (lower lane) strobe, active low |
| nb_dout | output | 16 | Separate-bus write data |
| nb_doe | output | 1 | Separate-bus data output enable |
| nb_din | input | 16 | Separate-bus read data |
| nb_dtack_n | input | 1 | Cycle-end acknowledge, active low |
| nb_size8 | input | 1 | Sampled with acknowledge: 1 means 8-bit port |
| mx_addr_hi | output | 16 | Address bits 23:8 in multiplexed form |
| mx_ad_out | output | 8 | Shared address/data pins, out |
| mx_ad_oe | output | 1 | Shared pins output enable |
| mx_ad_in | input | 8 | Shared address/data pins, in |
| mx_ale | output | 1 | Address latch enable |
| mx_rd_n | output | 1 | Multiplexed read strobe, active low |
| mx_wr_n | output | 1 | Multiplexed write strobe, active low |

## Verification
The bench builds the bridge with `MX_PHASE_CLKS`=3 rather than the default 2. The phase counter then has to count past a single wrap, and lengths of three clocks show that all three multiplexed phases follow the parameter, not a hard-wired value. The bench's separate-bus responder can hold off the acknowledge for a chosen number of clocks and answer as either port width. This covers the wait behaviour, the two-cycle split after an 8-bit answer, and the two lane choices for a lone odd byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef enum logic [2:0] {
        XB_IDLE,
        XB_NB_ACT,
        XB_NB_GAP,
        XB_MX_ALE,
        XB_MX_HOLD,
        XB_MX_DATA,
        XB_DONE
    } xb_state_e;

    localparam logic [LANES-1:0] LN_BOTH = 2'b11;
    localparam logic [LANES-1:0] LN_EVEN = 2'b10;
    localparam logic [LANES-1:0] LN_ODD  = 2'b01;

    // Lanes covered by the first external cycle of an access
    function automatic logic [LANES-1:0] first_lanes(input logic [LANES-1:0] be,
                                                     input logic mux);
        if (mux && be == LN_BOTH) return LN_EVEN;
        return be;
    endfunction

    // Address bit 0 of the current cycle
    function automatic logic is_odd(input logic [LANES-1:0] lanes);
        return lanes == LN_ODD;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [DATA_W-1:0] w,
                                                    input logic odd);
        return odd ? w[BYTE_W-1:0] : w[DATA_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int PH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_write,
    input  logic              req_mux,
    input  logic              nb_dtack_n,
    input  logic              nb_size8,
    output xb_state_e         state,
    output logic [LANES-1:0]  lanes,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_write,
    output logic              phase_last,
    output logic              accept
);
    localparam int CNT_W = (PH > 1) ? $clog2(PH) : 1;

    logic [CNT_W-1:0] cnt;
    logic [LANES-1:0] cur_be;

    assign phase_last = (cnt == CNT_W'(PH - 1));
    assign accept     = (state == XB_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= XB_IDLE;
            lanes     <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
            cur_be    <= '0;
            cnt       <= '0;
        end else begin
            case (state)
                XB_IDLE: begin
                    if (req_valid) begin
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        cur_write <= req_write;
                        cur_be    <= req_be;
                        lanes     <= first_lanes(req_be, req_mux);
                        cnt       <= '0;
                        if (req_be == '0)  state <= XB_DONE;
                        else if (req_mux)  state <= XB_MX_ALE;
                        else               state <= XB_NB_ACT;
                    end
                end
                XB_NB_ACT: begin
                    if (!nb_dtack_n) begin
                        if (lanes == LN_BOTH && nb_size8) begin
                            lanes <= LN_ODD;
                            state <= XB_NB_GAP;
                        end else begin
                            state <= XB_DONE;
                        end
                    end
                end
                XB_NB_GAP: state <= XB_NB_ACT;
                XB_MX_ALE: begin
                    if (phase_last) begin
                        cnt   <= '0;
                        state <= XB_MX_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XB_MX_HOLD: begin
                    if (phase_last) begin
                        cnt   <= '0;
                        state <= XB_MX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XB_MX_DATA: begin
                    if (phase_last) begin
                        cnt <= '0;
                        if (lanes == LN_EVEN && cur_be == LN_BOTH) begin
                            lanes <= LN_ODD;
                            state <= XB_MX_ALE;
                        end else begin
                            state <= XB_DONE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XB_DONE: state <= XB_IDLE;
                default: state <= XB_IDLE;
            endcase
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PH - 1));

    // R8
    odd_follows_even_chk: assert property (@(posedge clk) disable iff (rst)
        (state == XB_MX_DATA && phase_last && lanes == LN_EVEN && cur_be == LN_BOTH)
        |=> (state == XB_MX_ALE && lanes == LN_ODD));

endmodule

// File: rtl/xbus_nb_drive.sv
module xbus_nb_drive
    import xbus_pkg::*;
(
    input  xb_state_e         state,
    input  logic [LANES-1:0]  lanes,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic              cur_write,
    output logic [ADDR_W-1:0] nb_addr,
    output logic              nb_as_n,
    output logic              nb_rw,
    output logic              nb_uds_n,
    output logic              nb_lds_n,
    output logic [DATA_W-1:0] nb_dout,
    output logic              nb_doe
);
    logic active;
    logic odd;

    always_comb begin
        active   = (state == XB_NB_ACT);
        odd      = is_odd(lanes);
        nb_addr  = {cur_addr[ADDR_W-1:1], odd};
        nb_as_n  = !active;
        nb_rw    = !(active && cur_write);
        nb_uds_n = !(active && lanes[1]);
        nb_lds_n = !(active && lanes[0]);
        nb_doe   = active && cur_write;
        if (odd) nb_dout = {LANES{cur_wdata[BYTE_W-1:0]}};
        else     nb_dout = cur_wdata;
    end

endmodule

// File: rtl/xbus_mx_drive.sv
module xbus_mx_drive
    import xbus_pkg::*;
(
    input  xb_state_e                 state,
    input  logic [LANES-1:0]          lanes,
    input  logic [ADDR_W-1:0]         cur_addr,
    input  logic [DATA_W-1:0]         cur_wdata,
    input  logic                      cur_write,
    output logic [ADDR_W-BYTE_W-1:0]  mx_addr_hi,
    output logic [BYTE_W-1:0]         mx_ad_out,
    output logic                      mx_ad_oe,
    output logic                      mx_ale,
    output logic                      mx_rd_n,
    output logic                      mx_wr_n
);
    logic addr_ph;
    logic data_ph;
    logic odd;

    always_comb begin
        odd        = is_odd(lanes);
        addr_ph    = (state == XB_MX_ALE) || (state == XB_MX_HOLD);
        data_ph    = (state == XB_MX_DATA);
        mx_addr_hi = cur_addr[ADDR_W-1:BYTE_W];
        mx_ale     = (state == XB_MX_ALE);
        mx_rd_n    = !(data_ph && !cur_write);
        mx_wr_n    = !(data_ph && cur_write);
        mx_ad_oe   = addr_ph || (data_ph && cur_write);
        if (addr_ph) mx_ad_out = {cur_addr[BYTE_W-1:1], odd};
        else         mx_ad_out = pick_byte(cur_wdata, odd);
    end

endmodule

// File: rtl/xbus_rd_asm.sv
module xbus_rd_asm
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xb_state_e         state,
    input  logic [LANES-1:0]  lanes,
    input  logic              phase_last,
    input  logic              cur_write,
    input  logic              nb_dtack_n,
    input  logic              nb_size8,
    input  logic [DATA_W-1:0] nb_din,
    input  logic [BYTE_W-1:0] mx_ad_in,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI = DATA_W - 1;
    localparam int LO = BYTE_W - 1;

    logic nb_cap;
    logic mx_cap;

    assign nb_cap = (state == XB_NB_ACT) && !nb_dtack_n && !cur_write;
    assign mx_cap = (state == XB_MX_DATA) && phase_last && !cur_write;

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            rdata <= '0;
        end else if (nb_cap) begin
            case (lanes)
                LN_BOTH: begin
                    if (nb_size8) rdata[HI:BYTE_W] <= nb_din[HI:BYTE_W];
                    else          rdata <= nb_din;
                end
                LN_EVEN: rdata[HI:BYTE_W] <= nb_din[HI:BYTE_W];
                LN_ODD:  rdata[LO:0] <= nb_size8 ? nb_din[HI:BYTE_W] : nb_din[LO:0];
                default: rdata <= rdata;
            endcase
        end else if (mx_cap) begin
            if (is_odd(lanes)) rdata[LO:0] <= mx_ad_in;
            else               rdata[HI:BYTE_W] <= mx_ad_in;
        end
    end

endmodule

// File: rtl/dual_bus_bridge.sv
module dual_bus_bridge
    import xbus_pkg::*;
#(
    parameter int MX_PHASE_CLKS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [LANES-1:0]         req_be,
    input  logic                     req_write,
    input  logic                     req_mux,
    output logic                     req_ack,
    output logic [DATA_W-1:0]        req_rdata,
    output logic [ADDR_W-1:0]        nb_addr,
    output logic                     nb_as_n,
    output logic                     nb_rw,
    output logic                     nb_uds_n,
    output logic                     nb_lds_n,
    output logic [DATA_W-1:0]        nb_dout,
    output logic                     nb_doe,
    input  logic [DATA_W-1:0]        nb_din,
    input  logic                     nb_dtack_n,
    input  logic                     nb_size8,
    output logic [ADDR_W-BYTE_W-1:0] mx_addr_hi,
    output logic [BYTE_W-1:0]        mx_ad_out,
    output logic                     mx_ad_oe,
    input  logic [BYTE_W-1:0]        mx_ad_in,
    output logic                     mx_ale,
    output logic                     mx_rd_n,
    output logic                     mx_wr_n
);
    xb_state_e         state;
    logic [LANES-1:0]  lanes;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_write;
    logic              phase_last;
    logic              accept;

    xbus_seq #(.PH(MX_PHASE_CLKS)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_write(req_write), .req_mux(req_mux),
        .nb_dtack_n(nb_dtack_n), .nb_size8(nb_size8),
        .state(state), .lanes(lanes), .cur_addr(cur_addr),
        .cur_wdata(cur_wdata), .cur_write(cur_write),
        .phase_last(phase_last), .accept(accept)
    );

    xbus_nb_drive u_nb (
        .state(state), .lanes(lanes), .cur_addr(cur_addr),
        .cur_wdata(cur_wdata), .cur_write(cur_write),
        .nb_addr(nb_addr), .nb_as_n(nb_as_n), .nb_rw(nb_rw),
        .nb_uds_n(nb_uds_n), .nb_lds_n(nb_lds_n),
        .nb_dout(nb_dout), .nb_doe(nb_doe)
    );

    xbus_mx_drive u_mx (
        .state(state), .lanes(lanes), .cur_addr(cur_addr),
        .cur_wdata(cur_wdata), .cur_write(cur_write),
        .mx_addr_hi(mx_addr_hi), .mx_ad_out(mx_ad_out), .mx_ad_oe(mx_ad_oe),
        .mx_ale(mx_ale), .mx_rd_n(mx_rd_n), .mx_wr_n(mx_wr_n)
    );

    xbus_rd_asm u_rd (
        .clk(clk), .rst(rst), .accept(accept), .state(state), .lanes(lanes),
        .phase_last(phase_last), .cur_write(cur_write),
        .nb_dtack_n(nb_dtack_n), .nb_size8(nb_size8), .nb_din(nb_din),
        .mx_ad_in(mx_ad_in), .rdata(req_rdata)
    );

    assign req_ack = (state == XB_DONE);

    // R9
    ack_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    // R9
    ack_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (nb_as_n && mx_rd_n && mx_wr_n && !mx_ale));

    // R1
    one_form_chk: assert property (@(posedge clk) disable iff (rst)
        !(!nb_as_n && (mx_ale || !mx_rd_n || !mx_wr_n)));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mx_rd_n && !mx_wr_n));

    // R6
    ale_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mx_ale) |-> (mx_rd_n && mx_wr_n && mx_ad_oe));

    // R3
    nb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!nb_as_n && nb_dtack_n) |=>
        (!nb_as_n && $stable(nb_addr) && $stable(nb_uds_n) && $stable(nb_lds_n)));

endmodule

// File: tb/dual_bus_bridge_test.sv
module dual_bus_bridge_test;
    localparam int PH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic        req_mux = 1'b0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic [23:0] nb_addr;
    logic        nb_as_n, nb_rw, nb_uds_n, nb_lds_n, nb_doe;
    logic [15:0] nb_dout;
    logic [15:0] nb_din = '0;
    logic        nb_dtack_n = 1'b1;
    logic        nb_size8 = 1'b0;
    logic [15:0] mx_addr_hi;
    logic [7:0]  mx_ad_out;
    logic        mx_ad_oe;
    logic [7:0]  mx_ad_in = '0;
    logic        mx_ale, mx_rd_n, mx_wr_n;

    int total = 0;
    int passed = 0;

    always #5 clk = ~clk;

    dual_bus_bridge #(.MX_PHASE_CLKS(PH)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
        .req_mux(req_mux), .req_ack(req_ack), .req_rdata(req_rdata),
        .nb_addr(nb_addr), .nb_as_n(nb_as_n), .nb_rw(nb_rw),
        .nb_uds_n(nb_uds_n), .nb_lds_n(nb_lds_n), .nb_dout(nb_dout),
        .nb_doe(nb_doe), .nb_din(nb_din), .nb_dtack_n(nb_dtack_n),
        .nb_size8(nb_size8), .mx_addr_hi(mx_addr_hi), .mx_ad_out(mx_ad_out),
        .mx_ad_oe(mx_ad_oe), .mx_ad_in(mx_ad_in), .mx_ale(mx_ale),
        .mx_rd_n(mx_rd_n), .mx_wr_n(mx_wr_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    // Requester: issue one access, wait for acknowledge, check pulse width (R9)
    task automatic do_req(input logic [23:0] a, input logic [15:0] w,
                          input logic [1:0] be, input logic wr, input logic mx,
                          output logic [15:0] rd);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = w;
        req_be = be; req_write = wr; req_mux = mx;
        do begin
            @(negedge clk);
            n++;
        end while (!req_ack && n < 500);
        chk(req_ack, "R9 acknowledge seen", {31'd0, req_ack}, 1);
        rd = req_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ack, "R9 acknowledge lasts one clock", {31'd0, req_ack}, 0);
    endtask

    // Separate-bus responder for one cycle
    task automatic nb_resp(input logic [15:0] din_v, input logic size8,
                           input int waits, output logic [23:0] a,
                           output logic uds, output logic lds, output logic rw,
                           output logic [15:0] dout, output logic oe,
                           output bit held);
        while (nb_as_n) @(negedge clk);
        a = nb_addr; uds = nb_uds_n; lds = nb_lds_n; rw = nb_rw;
        dout = nb_dout; oe = nb_doe;
        held = !mx_ale && mx_rd_n && mx_wr_n && !req_ack;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            if (nb_as_n || nb_addr != a || nb_uds_n != uds || nb_lds_n != lds || req_ack)
                held = 1'b0;
        end
        nb_dtack_n = 1'b0; nb_din = din_v; nb_size8 = size8;
        @(negedge clk);
        nb_dtack_n = 1'b1; nb_size8 = 1'b0; nb_din = '0;
    endtask

    // Multiplexed responder for one byte cycle
    task automatic mx_byte(input logic [7:0] rd_byte, output logic [7:0] alo,
                           output logic [15:0] ahi, output logic [7:0] wbyte,
                           output logic was_wr, output int n_ale,
                           output int n_hold, output int n_data, output bit clean);
        n_ale = 0; n_hold = 0; n_data = 0; clean = 1'b1; wbyte = '0;
        alo = '0; ahi = '0;
        while (!mx_ale) @(negedge clk);
        while (mx_ale) begin
            alo = mx_ad_out; ahi = mx_addr_hi;
            if (!nb_as_n || req_ack || !mx_ad_oe) clean = 1'b0;
            n_ale++;
            @(negedge clk);
        end
        while (mx_rd_n && mx_wr_n) begin
            if (!mx_ad_oe || mx_ad_out != alo || !nb_as_n) clean = 1'b0;
            n_hold++;
            @(negedge clk);
        end
        was_wr = !mx_wr_n;
        mx_ad_in = rd_byte;
        while (!mx_rd_n || !mx_wr_n) begin
            if (was_wr) begin
                wbyte = mx_ad_out;
                if (!mx_ad_oe) clean = 1'b0;
            end else if (mx_ad_oe) clean = 1'b0;
            if (!nb_as_n || req_ack) clean = 1'b0;
            n_data++;
            @(negedge clk);
        end
        mx_ad_in = '0;
    endtask

    task automatic t_reset();
        chk(nb_as_n && nb_uds_n && nb_lds_n && !nb_doe, "R11 separate bus idle",
            {28'd0, nb_as_n, nb_uds_n, nb_lds_n, nb_doe}, 4'he);
        chk(!mx_ale && mx_rd_n && mx_wr_n && !mx_ad_oe, "R11 multiplexed idle",
            {28'd0, mx_ale, mx_rd_n, mx_wr_n, mx_ad_oe}, 4'h6);
        chk(!req_ack && req_rdata == 16'h0, "R11 ack and rdata clear",
            {15'd0, req_ack, req_rdata}, 0);
    endtask

    task automatic t_nb_word_write16();
        logic [15:0] rd, dout; logic [23:0] a; logic u, l, rw, oe; bit held;
        fork
            do_req(24'h12_3457, 16'hA1B2, 2'b11, 1'b1, 1'b0, rd);
            nb_resp(16'h0, 1'b0, 2, a, u, l, rw, dout, oe, held);
        join
        chk(a == 24'h12_3456, "R2 word address even", a, 24'h123456);
        chk(!u && !l && !rw && oe, "R2 both strobes, write",
            {28'd0, u, l, rw, oe}, 4'h1);
        chk(dout == 16'hA1B2, "R2 write data lanes", dout, 16'hA1B2);
        chk(held, "R3 cycle held through wait clocks, R1 mux pins idle", held, 1);
    endtask

    task automatic t_nb_word_read16();
        logic [15:0] rd, dout; logic [23:0] a; logic u, l, rw, oe; bit held;
        fork
            do_req(24'h00_0100, 16'h0, 2'b11, 1'b0, 1'b0, rd);
            nb_resp(16'h5A3C, 1'b0, 0, a, u, l, rw, dout, oe, held);
        join
        chk(rw && !oe, "R2 read direction", {30'd0, rw, oe}, 2'b10);
        chk(rd == 16'h5A3C, "R5 one-cycle word read", rd, 16'h5A3C);
    endtask

    task automatic t_nb_word_write8();
        logic [15:0] rd, d1, d2; logic [23:0] a1, a2; logic u1, l1, u2, l2, rw, oe;
        bit h1, h2;
        fork
            do_req(24'h40_0020, 16'hC3D4, 2'b11, 1'b1, 1'b0, rd);
            begin
                nb_resp(16'h0, 1'b1, 0, a1, u1, l1, rw, d1, oe, h1);
                nb_resp(16'h0, 1'b1, 1, a2, u2, l2, rw, d2, oe, h2);
            end
        join
        chk(a1 == 24'h40_0020 && d1[15:8] == 8'hC3, "R4 first byte cycle even",
            {a1, d1[15:8]}, {24'h400020, 8'hC3});
        chk(a2 == 24'h40_0021 && u2 && !l2, "R4 second cycle odd, lower strobe only",
            {a2, 6'd0, u2, l2}, {24'h400021, 8'h02});
        chk(d2 == 16'hD4D4, "R4 odd byte on both halves", d2, 16'hD4D4);
    endtask

    task automatic t_nb_word_read8();
        logic [15:0] rd, d1; logic [23:0] a1; logic u, l, rw, oe; bit h;
        fork
            do_req(24'h40_0030, 16'h0, 2'b11, 1'b0, 1'b0, rd);
            begin
                nb_resp(16'h7E11, 1'b1, 0, a1, u, l, rw, d1, oe, h);
                nb_resp(16'h9F22, 1'b1, 0, a1, u, l, rw, d1, oe, h);
            end
        join
        chk(rd == 16'h7E9F, "R4 word assembled from two upper-lane bytes", rd, 16'h7E9F);
    endtask

    task automatic t_nb_odd_reads();
        logic [15:0] rd, d1; logic [23:0] a; logic u, l, rw, oe; bit h;
        fork
            do_req(24'h00_0203, 16'h0, 2'b01, 1'b0, 1'b0, rd);
            nb_resp(16'h3355, 1'b0, 0, a, u, l, rw, d1, oe, h);
        join
        chk(a == 24'h00_0203 && u && !l, "R2 odd byte address and strobe",
            {a, 6'd0, u, l}, {24'h000203, 8'h02});
        chk(rd == 16'h0055, "R5 odd byte from lower lane, R9 unused byte zero", rd, 16'h0055);
        fork
            do_req(24'h00_0203, 16'h0, 2'b01, 1'b0, 1'b0, rd);
            nb_resp(16'h3355, 1'b1, 0, a, u, l, rw, d1, oe, h);
        join
        chk(rd == 16'h0033, "R5 odd byte from 8-bit port upper lane", rd, 16'h0033);
    endtask

    task automatic t_nb_even_write();
        logic [15:0] rd, d; logic [23:0] a; logic u, l, rw, oe; bit h;
        fork
            do_req(24'h00_0A0A, 16'hEE00, 2'b10, 1'b1, 1'b0, rd);
            nb_resp(16'h0, 1'b0, 0, a, u, l, rw, d, oe, h);
        join
        chk(a == 24'h00_0A0A && !u && l && d[15:8] == 8'hEE,
            "R2 even byte upper strobe only", {a, d[15:8]}, {24'h000A0A, 8'hEE});
    endtask

    task automatic t_mx_byte_write();
        logic [15:0] rd, ahi; logic [7:0] alo, wb; logic wr; int na, nh, nd; bit cl;
        fork
            do_req(24'hAB_CD10, 16'h6600, 2'b10, 1'b1, 1'b1, rd);
            mx_byte(8'h00, alo, ahi, wb, wr, na, nh, nd, cl);
        join
        chk(na == PH && nh == PH && nd == PH, "R6 phase lengths",
            {8'd0, na[7:0], nh[7:0], nd[7:0]}, {8'd0, 8'(PH), 8'(PH), 8'(PH)});
        chk(alo == 8'h10 && ahi == 16'hABCD, "R6 address on shared and high pins",
            {ahi, alo}, 24'hABCD10);
        chk(wr && wb == 8'h66, "R7 write byte during write strobe", {wr, wb}, 9'h166);
        chk(cl, "R1 separate bus idle during multiplexed cycle", cl, 1);
    endtask

    task automatic t_mx_word_read();
        logic [15:0] rd, ahi; logic [7:0] a1, a2, wb; logic wr1, wr2;
        int na, nh, nd, na2, nh2, nd2; bit c1, c2;
        fork
            do_req(24'h01_02F5, 16'h0, 2'b11, 1'b0, 1'b1, rd);
            begin
                mx_byte(8'h8C, a1, ahi, wb, wr1, na, nh, nd, c1);
                mx_byte(8'h4D, a2, ahi, wb, wr2, na2, nh2, nd2, c2);
            end
        join
        chk(a1 == 8'hF4 && a2 == 8'hF5, "R8 even byte cycle before odd",
            {a1, a2}, 16'hF4F5);
        chk(!wr1 && !wr2 && c1 && c2, "R7 read strobe with pins released",
            {wr1, wr2, c1, c2}, 4'h3);
        chk(rd == 16'h8C4D, "R8 read bytes assembled", rd, 16'h8C4D);
        chk(na2 == PH && nd2 == PH, "R6 second byte phase lengths",
            {na2[15:0], nd2[15:0]}, {16'(PH), 16'(PH)});
    endtask

    task automatic t_mx_word_write();
        logic [15:0] rd, ahi; logic [7:0] a1, a2, w1, w2; logic wr1, wr2;
        int na, nh, nd; bit c1, c2;
        fork
            do_req(24'h00_0040, 16'h1357, 2'b11, 1'b1, 1'b1, rd);
            begin
                mx_byte(8'h00, a1, ahi, w1, wr1, na, nh, nd, c1);
                mx_byte(8'h00, a2, ahi, w2, wr2, na, nh, nd, c2);
            end
        join
        chk(w1 == 8'h13 && w2 == 8'h57 && a2 == 8'h41, "R8 write bytes even then odd",
            {a2, w1, w2}, 24'h411357);
    endtask

    task automatic t_no_bytes();
        logic [15:0] rd;
        bit quiet = 1'b1;
        fork
            do_req(24'h00_0000, 16'hFFFF, 2'b00, 1'b1, 1'b0, rd);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (!nb_as_n || mx_ale || !mx_wr_n || !mx_rd_n) quiet = 1'b0;
            end
        join
        chk(quiet, "R10 no external cycle for empty byte enables", quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nb_word_write16();
        t_nb_word_read16();
        t_nb_word_write8();
        t_nb_word_read8();
        t_nb_odd_reads();
        t_nb_even_write();
        t_mx_byte_write();
        t_mx_word_read();
        t_mx_word_write();
        t_no_bytes();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule